// File: doc/BRIEF.md
# Address-Space Decoder with Read Gating

This block sits between a 16-bit CPU address bus and the memories of a small handheld-style system. Every cycle it turns the address into exactly one region select and a region-local address. The regions are boot ROM, cartridge space, video RAM, external RAM, two work RAM banks, the sprite attribute table, an unusable gap, the I/O registers and the high RAM / interrupt-enable page. The range 0xE000–0xFDFF is an echo of work RAM. It decodes through the low 13 address bits and lands in one of the two work RAM banks.

Writes are passed to the selected region through a single write-enable output, and writes into the gap are dropped. The region memories are synchronous, so the block registers which region was read and whether that read was allowed. On the following cycle it returns that region's data, or 0xFF when the read was blocked. Reads are blocked by the display mode for the sprite table and video RAM, and always blocked in the gap.

Top module: `mem_map_decoder`

## Requirements
- R1: Addresses 0x0000–0x7FFF assert `sel_cart`, except for the boot overlay of R2. Writes there raise `mem_we`, so they reach the cartridge controller.
- R2: When `boot_en` is 1 and `wr_en` is 0, addresses below 0x0100 assert `sel_boot` instead of `sel_cart`. A write below 0x0100 always selects the cartridge.
- R3: 0x8000–0x9FFF asserts `sel_vram` and 0xA000–0xBFFF asserts `sel_xram`.
- R4: 0xC000–0xCFFF asserts `sel_wram0` and 0xD000–0xDFFF asserts `sel_wramx`.
- R5: 0xE000–0xFDFF mirrors work RAM through address AND 0x1FFF. An offset of 0x0000–0x0FFF selects bank 0 and an offset of 0x1000–0x1DFF selects the switchable bank.
- R6: `ppu_mode` is encoded as 0 horizontal blank, 1 vertical blank, 2 sprite scan and 3 pixel transfer. A read of 0xFE00–0xFE9F returns sprite table data only in modes 0 and 1, and returns 0xFF otherwise. Writes there are not gated.
- R7: A video RAM read made in mode 3 returns 0xFF. In any other mode it returns video RAM data.
- R8: 0xFEA0–0xFEFF asserts `sel_gap`. Writes there leave `mem_we` low, and reads there return 0xFF.
- R9: 0xFF00–0xFF7F asserts `sel_io`.
- R10: 0xFF80–0xFFFF asserts `sel_hram`.
- R11: Exactly one select output is high for every address and control combination.
- R12: `rd_data` shows the result of the access presented one clock earlier. Both during reset and after it, `rd_data` is 0xFF until the first clock edge after release.
- R13: `loc_addr` gives the in-region offset: address bits [14:0] for boot ROM and cartridge, [12:0] for video RAM and external RAM, [11:0] for work RAM and echo, [7:0] for the sprite table and gap, and [6:0] for I/O and high RAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | CPU address |
| wr_en | input | 1 | Write strobe |
| boot_en | input | 1 | Boot ROM overlay enabled |
| ppu_mode | input | 2 | Display mode (0 hblank, 1 vblank, 2 scan, 3 transfer) |
| boot_rdata | input | 8 | Boot ROM read data |
| cart_rdata | input | 8 | Cartridge read data |
| vram_rdata | input | 8 | Video RAM read data |
| xram_rdata | input | 8 | External RAM read data |
| wram0_rdata | input | 8 | Work RAM bank 0 read data |
| wramx_rdata | input | 8 | Switchable work RAM bank read data |
| oam_rdata | input | 8 | Sprite table read data |
| io_rdata | input | 8 | I/O register read data |
| hram_rdata | input | 8 | High RAM / interrupt-enable read data |
| sel_boot | output | 1 | Boot ROM select |
| sel_cart | output | 1 | Cartridge select |
| sel_vram | output | 1 | Video RAM select |
| sel_xram | output | 1 | External RAM select |
| sel_wram0 | output | 1 | Work RAM bank 0 select |
| sel_wramx | output | 1 | Switchable work RAM select |
| sel_oam | output | 1 | Sprite table select |
| sel_gap | output | 1 | Unusable gap select |
| sel_io | output | 1 | I/O register select |
| sel_hram | output | 1 | High RAM select |
| loc_addr | output | 15 | Region-local address |
| mem_we | output | 1 | Write enable to the selected region |
| rd_data | output | 8 | Merged read data, one cycle after the access |

## Verification
The assertions check on every cycle that the selects stay one-hot (R11) and that the boot select appears only under its own conditions (R2). They also check that gap writes never reach `mem_we` (R8), that echo addresses land in a work RAM bank (R5), and that gated sprite-table, video RAM and gap reads return 0xFF on the next cycle (R6, R7, R8). Only the bench's scenarios show the exact region boundaries, the translated offsets, which region's data comes back for an allowed read, and the reset value of `rd_data`.

// File: rtl/mem_map_decoder.sv
module mem_map_decoder #(
  parameter int DW = 8,
  parameter int LW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [15:0]   addr,
  input  logic          wr_en,
  input  logic          boot_en,
  input  logic [1:0]    ppu_mode,
  input  logic [DW-1:0] boot_rdata,
  input  logic [DW-1:0] cart_rdata,
  input  logic [DW-1:0] vram_rdata,
  input  logic [DW-1:0] xram_rdata,
  input  logic [DW-1:0] wram0_rdata,
  input  logic [DW-1:0] wramx_rdata,
  input  logic [DW-1:0] oam_rdata,
  input  logic [DW-1:0] io_rdata,
  input  logic [DW-1:0] hram_rdata,
  output logic          sel_boot,
  output logic          sel_cart,
  output logic          sel_vram,
  output logic          sel_xram,
  output logic          sel_wram0,
  output logic          sel_wramx,
  output logic          sel_oam,
  output logic          sel_gap,
  output logic          sel_io,
  output logic          sel_hram,
  output logic [LW-1:0] loc_addr,
  output logic          mem_we,
  output logic [DW-1:0] rd_data
);

  localparam int NRG = 10;
  localparam logic [DW-1:0] BLOCKED = '1;
  localparam logic [1:0] MODE_XFER = 2'd3;

  typedef enum logic [3:0] {
    RG_BOOT, RG_CART, RG_VRAM, RG_XRAM, RG_WRAM0,
    RG_WRAMX, RG_OAM, RG_GAP, RG_IO, RG_HRAM
  } region_t;

  region_t       region, rd_region;
  logic          read_ok, rd_ok;
  logic [NRG-1:0] sel_bus;

  always_comb begin
    if (addr < 16'h8000)
      region = (boot_en && !wr_en && addr < 16'h0100) ? RG_BOOT : RG_CART;
    else if (addr < 16'hA000) region = RG_VRAM;
    else if (addr < 16'hC000) region = RG_XRAM;
    else if (addr < 16'hD000) region = RG_WRAM0;
    else if (addr < 16'hE000) region = RG_WRAMX;
    else if (addr < 16'hFE00) region = addr[12] ? RG_WRAMX : RG_WRAM0;
    else if (addr < 16'hFEA0) region = RG_OAM;
    else if (addr < 16'hFF00) region = RG_GAP;
    else if (addr < 16'hFF80) region = RG_IO;
    else                      region = RG_HRAM;
  end

  for (genvar i = 0; i < NRG; i++) begin : g_sel
    assign sel_bus[i] = (region == region_t'(i));
  end

  assign sel_boot  = sel_bus[RG_BOOT];
  assign sel_cart  = sel_bus[RG_CART];
  assign sel_vram  = sel_bus[RG_VRAM];
  assign sel_xram  = sel_bus[RG_XRAM];
  assign sel_wram0 = sel_bus[RG_WRAM0];
  assign sel_wramx = sel_bus[RG_WRAMX];
  assign sel_oam   = sel_bus[RG_OAM];
  assign sel_gap   = sel_bus[RG_GAP];
  assign sel_io    = sel_bus[RG_IO];
  assign sel_hram  = sel_bus[RG_HRAM];

  always_comb begin
    loc_addr = '0;
    unique case (region)
      RG_BOOT, RG_CART:   loc_addr = LW'(addr[14:0]);
      RG_VRAM, RG_XRAM:   loc_addr = LW'(addr[12:0]);
      RG_WRAM0, RG_WRAMX: loc_addr = LW'(addr[11:0]);
      RG_OAM, RG_GAP:     loc_addr = LW'(addr[7:0]);
      default:            loc_addr = LW'(addr[6:0]);
    endcase
  end

  always_comb begin
    unique case (region)
      RG_VRAM: read_ok = (ppu_mode != MODE_XFER);
      RG_OAM:  read_ok = !ppu_mode[1];
      RG_GAP:  read_ok = 1'b0;
      default: read_ok = 1'b1;
    endcase
  end

  assign mem_we = wr_en && (region != RG_GAP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_region <= RG_GAP;
      rd_ok     <= 1'b0;
    end else begin
      rd_region <= region;
      rd_ok     <= read_ok;
    end
  end

  always_comb begin
    rd_data = BLOCKED;
    if (rd_ok) begin
      unique case (rd_region)
        RG_BOOT:  rd_data = boot_rdata;
        RG_CART:  rd_data = cart_rdata;
        RG_VRAM:  rd_data = vram_rdata;
        RG_XRAM:  rd_data = xram_rdata;
        RG_WRAM0: rd_data = wram0_rdata;
        RG_WRAMX: rd_data = wramx_rdata;
        RG_OAM:   rd_data = oam_rdata;
        RG_IO:    rd_data = io_rdata;
        RG_HRAM:  rd_data = hram_rdata;
        default:  rd_data = BLOCKED;
      endcase
    end
  end

endmodule

// File: rtl/mem_map_decoder_chk.sv
module mem_map_decoder_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [15:0]   addr,
  input logic          wr_en,
  input logic          boot_en,
  input logic [1:0]    ppu_mode,
  input logic [9:0]    sels,
  input logic          mem_we,
  input logic [DW-1:0] rd_data
);

  // sels order: {hram, io, gap, oam, wramx, wram0, xram, vram, cart, boot}

  p_one_select_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(sels) == 1);

  p_boot_cond_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sels[0] |-> (boot_en && !wr_en && addr < 16'h0100));

  p_gap_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sels[7] && wr_en) |-> !mem_we);

  p_gap_read_ff_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sels[7] |=> rd_data == '1);

  p_oam_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sels[6] && ppu_mode[1]) |=> rd_data == '1);

  p_vram_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sels[2] && ppu_mode == 2'd3) |=> rd_data == '1);

  p_echo_bank_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (addr >= 16'hE000 && addr < 16'hFE00) |-> (sels[4] != sels[5]) && (sels[5] == addr[12]));

endmodule

bind mem_map_decoder mem_map_decoder_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .boot_en(boot_en),
  .ppu_mode(ppu_mode),
  .sels({sel_hram, sel_io, sel_gap, sel_oam, sel_wramx, sel_wram0, sel_xram, sel_vram, sel_cart, sel_boot}),
  .mem_we(mem_we), .rd_data(rd_data)
);

// File: tb/mem_map_decoder_test.sv
module mem_map_decoder_test;
  localparam int PERIOD = 10;
  localparam int NV = 29;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic wr_en = 1'b0, boot_en = 1'b0;
  logic [1:0] ppu_mode = '0;
  logic sel_boot, sel_cart, sel_vram, sel_xram, sel_wram0, sel_wramx, sel_oam, sel_gap, sel_io, sel_hram;
  logic [14:0] loc_addr;
  logic mem_we;
  logic [7:0] rd_data;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  mem_map_decoder uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .boot_en(boot_en), .ppu_mode(ppu_mode),
    .boot_rdata(8'hB0), .cart_rdata(8'hCA), .vram_rdata(8'h90), .xram_rdata(8'hA5),
    .wram0_rdata(8'hC0), .wramx_rdata(8'hD1), .oam_rdata(8'hFE), .io_rdata(8'hF0), .hram_rdata(8'h8F),
    .sel_boot(sel_boot), .sel_cart(sel_cart), .sel_vram(sel_vram), .sel_xram(sel_xram),
    .sel_wram0(sel_wram0), .sel_wramx(sel_wramx), .sel_oam(sel_oam), .sel_gap(sel_gap),
    .sel_io(sel_io), .sel_hram(sel_hram), .loc_addr(loc_addr), .mem_we(mem_we), .rd_data(rd_data)
  );

  wire [9:0] sels = {sel_hram, sel_io, sel_gap, sel_oam, sel_wramx, sel_wram0, sel_xram, sel_vram, sel_cart, sel_boot};

  // {req4, addr16, boot1, mode2, wr1, sel10, loc15, rd8, we1}
  localparam logic [57:0] VEC [NV] = '{
    {4'd2,  16'h0050, 1'b1, 2'd0, 1'b0, 10'h001, 15'h0050, 8'hB0, 1'b0}, // R2
    {4'd1,  16'h0050, 1'b0, 2'd0, 1'b0, 10'h002, 15'h0050, 8'hCA, 1'b0}, // R1
    {4'd2,  16'h0050, 1'b1, 2'd0, 1'b1, 10'h002, 15'h0050, 8'hCA, 1'b1}, // R2
    {4'd2,  16'h00FF, 1'b1, 2'd0, 1'b0, 10'h001, 15'h00FF, 8'hB0, 1'b0}, // R2
    {4'd2,  16'h0100, 1'b1, 2'd0, 1'b0, 10'h002, 15'h0100, 8'hCA, 1'b0}, // R2
    {4'd1,  16'h7FFF, 1'b0, 2'd0, 1'b1, 10'h002, 15'h7FFF, 8'hCA, 1'b1}, // R1
    {4'd3,  16'h8000, 1'b0, 2'd0, 1'b0, 10'h004, 15'h0000, 8'h90, 1'b0}, // R3
    {4'd7,  16'h9FFF, 1'b0, 2'd3, 1'b0, 10'h004, 15'h1FFF, 8'hFF, 1'b0}, // R7
    {4'd7,  16'h9ABC, 1'b0, 2'd2, 1'b0, 10'h004, 15'h1ABC, 8'h90, 1'b0}, // R7
    {4'd3,  16'hA123, 1'b0, 2'd3, 1'b0, 10'h008, 15'h0123, 8'hA5, 1'b0}, // R3
    {4'd13, 16'hBFFF, 1'b0, 2'd0, 1'b0, 10'h008, 15'h1FFF, 8'hA5, 1'b0}, // R13
    {4'd4,  16'hC000, 1'b0, 2'd0, 1'b0, 10'h010, 15'h0000, 8'hC0, 1'b0}, // R4
    {4'd4,  16'hCFFF, 1'b0, 2'd0, 1'b1, 10'h010, 15'h0FFF, 8'hC0, 1'b1}, // R4
    {4'd4,  16'hD000, 1'b0, 2'd0, 1'b0, 10'h020, 15'h0000, 8'hD1, 1'b0}, // R4
    {4'd5,  16'hE123, 1'b0, 2'd0, 1'b0, 10'h010, 15'h0123, 8'hC0, 1'b0}, // R5
    {4'd5,  16'hF456, 1'b0, 2'd0, 1'b0, 10'h020, 15'h0456, 8'hD1, 1'b0}, // R5
    {4'd5,  16'hFDFF, 1'b0, 2'd0, 1'b1, 10'h020, 15'h0DFF, 8'hD1, 1'b1}, // R5
    {4'd6,  16'hFE00, 1'b0, 2'd0, 1'b0, 10'h040, 15'h0000, 8'hFE, 1'b0}, // R6
    {4'd6,  16'hFE9F, 1'b0, 2'd1, 1'b0, 10'h040, 15'h009F, 8'hFE, 1'b0}, // R6
    {4'd6,  16'hFE10, 1'b0, 2'd2, 1'b0, 10'h040, 15'h0010, 8'hFF, 1'b0}, // R6
    {4'd6,  16'hFE10, 1'b0, 2'd3, 1'b0, 10'h040, 15'h0010, 8'hFF, 1'b0}, // R6
    {4'd8,  16'hFEA0, 1'b0, 2'd0, 1'b1, 10'h080, 15'h00A0, 8'hFF, 1'b0}, // R8
    {4'd8,  16'hFEFF, 1'b0, 2'd0, 1'b0, 10'h080, 15'h00FF, 8'hFF, 1'b0}, // R8
    {4'd9,  16'hFF00, 1'b0, 2'd0, 1'b0, 10'h100, 15'h0000, 8'hF0, 1'b0}, // R9
    {4'd9,  16'hFF7F, 1'b0, 2'd0, 1'b1, 10'h100, 15'h007F, 8'hF0, 1'b1}, // R9
    {4'd10, 16'hFF80, 1'b0, 2'd0, 1'b0, 10'h200, 15'h0000, 8'h8F, 1'b0}, // R10
    {4'd10, 16'hFFFF, 1'b0, 2'd0, 1'b1, 10'h200, 15'h007F, 8'h8F, 1'b1}, // R10
    {4'd6,  16'hFE00, 1'b0, 2'd0, 1'b1, 10'h040, 15'h0000, 8'hFE, 1'b1}, // R6
    {4'd6,  16'hFE50, 1'b0, 2'd3, 1'b1, 10'h040, 15'h0050, 8'hFF, 1'b1}  // R6
  };

  task automatic check(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  initial begin
    #(PERIOD*20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R12: reset state
    addr = 16'hC000;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(12, "rd_data in reset", rd_data, 8'hFF);
    check(11, "one select in reset", $countones(sels), 1);
    rst_n = 1'b1;
    #1 check(12, "rd_data after release", rd_data, 8'hFF);
    @(posedge clk); #1;
    check(12, "rd_data first edge", rd_data, 8'hC0);

    for (int i = 0; i < NV; i++) begin
      logic [57:0] v;
      v = VEC[i];
      @(negedge clk);
      addr = v[53:38]; boot_en = v[37]; ppu_mode = v[36:35]; wr_en = v[34];
      #1;
      check(int'(v[57:54]), $sformatf("sel @%h", v[53:38]), sels, v[33:24]);
      check(11, $sformatf("one-hot @%h", v[53:38]), $countones(sels), 1);
      check(13, $sformatf("loc_addr @%h", v[53:38]), loc_addr, v[23:9]);
      check(int'(v[57:54]), $sformatf("mem_we @%h", v[53:38]), mem_we, v[0]);
      @(posedge clk); #1;
      check(int'(v[57:54]), $sformatf("rd_data @%h", v[53:38]), rd_data, v[8:1]);
    end

    // R12: one-cycle latency, data tracks previous access not current
    @(negedge clk);
    wr_en = 0; boot_en = 0; ppu_mode = 0; addr = 16'hA000;
    @(posedge clk); #1;
    addr = 16'hFEC0;
    #1 check(12, "rd_data before edge holds prior access", rd_data, 8'hA5);
    @(posedge clk); #1;
    check(8, "gap read blocked", rd_data, 8'hFF);

    // R7: vram readable in sprite scan but not transfer, back to back
    @(negedge clk); addr = 16'h8800; ppu_mode = 2'd3;
    @(posedge clk); #1; check(7, "vram mode3", rd_data, 8'hFF);
    @(negedge clk); ppu_mode = 2'd1;
    @(posedge clk); #1; check(7, "vram mode1", rd_data, 8'h90);

    // R12: reset mid-stream forces 0xFF
    @(negedge clk); rst_n = 1'b0;
    #1 check(12, "async reset", rd_data, 8'hFF);
    @(negedge clk); rst_n = 1'b1;

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule